// File: doc/BRIEF.md
# Clocked Controller for a 16-bit Asynchronous SRAM

This block sits between a clocked host and an asynchronous static RAM of 16-bit words. The host offers one single-beat request at a time on a valid/ready port: read or write, an 18-bit word address, write data and a two-bit byte mask. The controller turns each request into a sequence of strobes on the memory pins. The phases are write setup, write-enable pulse and recovery for a write, and output-enable access, sample and bus float for a read. The address, data and byte-enable pins are held steady across every phase.

Each phase lasts a whole number of clock cycles. That number is computed when the block is built, from nanosecond limits and the clock period. Each limit is divided by the period and rounded up, with a floor of one cycle. Writes are framed by the write-enable pulse, and reads are framed by output enable. After every read the controller waits out the time during which the memory may still drive the bus, so the next write can drive data with no contention. Chip enable is released whenever the controller is idle, which lets the memory drop into standby between transactions.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, req_ready is 1, all active-low strobes (chip, write, output, upper and lower byte enable) are 1, sram_dq_oe is 0 and rsp_valid is 0.
- R2: req_ready is 1 only when idle, and a request is taken on a clock edge where req_valid and req_ready are both 1. Chip enable is high whenever req_ready is 1. A request offered while req_ready is 0 is ignored: it causes no strobe and no memory change.
- R3: A read drives the address with chip enable and output enable low and write enable high for RD = max(ceil(T_ACCESS/P), ceil(T_OE_ACCESS/P)) cycles (14 at 55/25 ns and 4 ns). It then holds them for one more sample cycle, and the data pins are captured at the end of that cycle.
- R4: rsp_valid is a single-cycle pulse in cycle RD+2 after the accepting edge. rsp_rdata holds the captured data, with bits 15:8 forced to zero unless mask bit 1 is set and bits 7:0 forced to zero unless mask bit 0 is set.
- R5: After a read, output enable stays high for FL = max(1, ceil(T_FLOAT/P)) cycles (5) before idle. The data drivers are never enabled until at least FL cycles after output enable rose.
- R6: A write starts with SU = max(1, ceil(T_ADDR_SETUP/P)) setup cycles (1). In these cycles chip enable is low, write enable is high, and the address and data are driven.
- R7: Write enable is then low for PW = max(ceil(T_WE_PULSE/P), ceil(T_DATA_SETUP/P) - SU, 1) cycles (10). Data is driven and stable from the setup cycle until write enable rises.
- R8: A recovery phase of RC = max(1, ceil(T_WRITE_CYCLE/P) - SU - PW) cycles (3) follows, with write enable high, data drivers off and the address unchanged. The controller then returns to idle in cycle SU+PW+RC+1.
- R9: Byte-enable pins are active-low copies of the mask (bit 1 drives the upper enable, bit 0 the lower) while chip enable is low. Only selected lanes of the memory word change on a write.
- R10: Output enable and write enable are never low together, and the data drivers are never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable for the data drivers |
| sram_dq_in | input | 16 | Data received from the memory |

## Verification
Every result is tied to the accepting edge. With the default 4 ns clock, the read response pulses in cycle 16 after acceptance and the controller is ready again in cycle 21. A write holds write enable low over cycles 2 to 11 and is idle again in cycle 15. The bench recomputes these cycle numbers from the nanosecond limits with its own arithmetic and compares the full strobe vector at the falling edge of every cycle of every transaction. Its memory model returns garbage until the access time has elapsed, drives junk on deselected lanes, and on each write-enable rise checks the pulse length and that address and data were held.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_SAMPLE,
    ST_RD_FLOAT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Whole clock cycles covering a nanosecond limit, never fewer than one.
  function automatic int ns_cycles(input int ns, input int period);
    return max2(1, (ns + period - 1) / period);
  endfunction

  function automatic int rd_cycles(input int t_acc, input int t_oe, input int period);
    return max2(ns_cycles(t_acc, period), ns_cycles(t_oe, period));
  endfunction

  function automatic int su_cycles(input int t_asu, input int period);
    return ns_cycles(t_asu, period);
  endfunction

  // Data is driven from the setup cycle on, so setup cycles count toward data setup.
  function automatic int pw_cycles(input int t_wp, input int t_dsu, input int su, input int period);
    return max2(1, max2(ns_cycles(t_wp, period), ns_cycles(t_dsu, period) - su));
  endfunction

  function automatic int rc_cycles(input int t_wc, input int su, input int pw, input int period);
    return max2(1, ns_cycles(t_wc, period) - su - pw);
  endfunction

  function automatic int fl_cycles(input int t_fl, input int period);
    return ns_cycles(t_fl, period);
  endfunction

  function automatic int bits_for(input int maxval);
    return max2(1, $clog2(maxval + 1));
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC = 14,
  parameter int FL_CYC = 5,
  parameter int SU_CYC = 1,
  parameter int PW_CYC = 10,
  parameter int RC_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output seq_state_e state,
  output logic       accept,
  output logic       sample,
  output logic       pulse_end
);

  localparam int MAXPH = max2(max2(RD_CYC, FL_CYC), max2(max2(SU_CYC, PW_CYC), RC_CYC));
  localparam int CW    = bits_for(MAXPH);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] FL_LD = CW'(FL_CYC - 1);
  localparam logic [CW-1:0] SU_LD = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] PW_LD = CW'(PW_CYC - 1);
  localparam logic [CW-1:0] RC_LD = CW'(RC_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_write) begin
              state_d = ST_WR_SETUP;
              cnt_d   = SU_LD;
            end else begin
              state_d = ST_RD_ACCESS;
              cnt_d   = RD_LD;
            end
          end
        end
        ST_RD_ACCESS: begin
          state_d = ST_RD_SAMPLE;
          cnt_d   = '0;
        end
        ST_RD_SAMPLE: begin
          state_d = ST_RD_FLOAT;
          cnt_d   = FL_LD;
        end
        ST_WR_SETUP: begin
          state_d = ST_WR_PULSE;
          cnt_d   = PW_LD;
        end
        ST_WR_PULSE: begin
          state_d = ST_WR_RECOVER;
          cnt_d   = RC_LD;
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state     = state_q;
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign sample    = (state_q == ST_RD_SAMPLE);
  assign pulse_end = (state_q == ST_WR_PULSE) && (cnt_q == '0);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_bmask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] lane_data;

  // Deselected lanes float on the pins, so they are replaced by zero.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_data[8*l +: 8] = mask_q[l] ? dq_in[8*l +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_bmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_rdata <= lane_data;
    end
  end

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int LANES = 2
) (
  input  seq_state_e       state,
  input  logic [LANES-1:0] mask,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe
);

  logic active;

  assign active = (state != ST_IDLE);
  assign ce_n   = !active;
  assign we_n   = (state != ST_WR_PULSE);
  assign oe_n   = !((state == ST_RD_ACCESS) || (state == ST_RD_SAMPLE));
  assign dq_oe  = (state == ST_WR_SETUP) || (state == ST_WR_PULSE);

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_n[l] = !(active && mask[l]);
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter int CLK_PERIOD_NS    = 4,
  parameter int T_ACCESS_NS      = 55,
  parameter int T_OE_ACCESS_NS   = 25,
  parameter int T_FLOAT_NS       = 20,
  parameter int T_ADDR_SETUP_NS  = 0,
  parameter int T_WE_PULSE_NS    = 40,
  parameter int T_DATA_SETUP_NS  = 25,
  parameter int T_WRITE_CYCLE_NS = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_bmask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_in
);

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = rd_cycles(T_ACCESS_NS, T_OE_ACCESS_NS, CLK_PERIOD_NS);
  localparam int FL_CYC = fl_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int SU_CYC = su_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int PW_CYC = pw_cycles(T_WE_PULSE_NS, T_DATA_SETUP_NS, SU_CYC, CLK_PERIOD_NS);
  localparam int RC_CYC = rc_cycles(T_WRITE_CYCLE_NS, SU_CYC, PW_CYC, CLK_PERIOD_NS);

  // Named internal events, also observed by the bound checker.
  seq_state_e       cur_state;
  logic             ev_accept;
  logic             ev_sample;
  logic             ev_pulse_end;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] be_n;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .FL_CYC(FL_CYC), .SU_CYC(SU_CYC), .PW_CYC(PW_CYC), .RC_CYC(RC_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .state     (cur_state),
    .accept    (ev_accept),
    .sample    (ev_sample),
    .pulse_end (ev_pulse_end)
  );

  sram_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .sample    (ev_sample),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_bmask (req_bmask),
    .dq_in     (sram_dq_in),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .mask_q    (mask_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  sram_seq_pins #(
    .LANES(LANES)
  ) u_pins (
    .state (cur_state),
    .mask  (mask_q),
    .ce_n  (sram_ce_n),
    .we_n  (sram_we_n),
    .oe_n  (sram_oe_n),
    .be_n  (be_n),
    .dq_oe (sram_dq_oe)
  );

  assign sram_ub_n = be_n[1];
  assign sram_lb_n = be_n[0];

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter int CLK_PERIOD_NS    = 4,
  parameter int T_ACCESS_NS      = 55,
  parameter int T_OE_ACCESS_NS   = 25,
  parameter int T_FLOAT_NS       = 20,
  parameter int T_ADDR_SETUP_NS  = 0,
  parameter int T_WE_PULSE_NS    = 40,
  parameter int T_DATA_SETUP_NS  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ev_accept,
  input logic              ev_sample,
  input logic              ev_pulse_end,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic              sram_dq_oe,
  input logic [15:0]       sram_dq_out
);

  localparam int RD = rd_cycles(T_ACCESS_NS, T_OE_ACCESS_NS, CLK_PERIOD_NS);
  localparam int FL = fl_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int SU = su_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int PW = pw_cycles(T_WE_PULSE_NS, T_DATA_SETUP_NS, SU, CLK_PERIOD_NS);
  localparam int RW = bits_for(max2(RD, max2(FL, PW)) + 1);
  localparam logic [RW-1:0] SAT = '1;

  logic [RW-1:0] oe_low_run, oe_high_run, we_low_run;
  logic          dq_oe_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_low_run  <= '0;
      oe_high_run <= SAT;
      we_low_run  <= '0;
      dq_oe_prev  <= 1'b0;
    end else begin
      oe_low_run  <= sram_oe_n ? '0 : ((oe_low_run == SAT) ? SAT : oe_low_run + 1'b1);
      oe_high_run <= !sram_oe_n ? '0 : ((oe_high_run == SAT) ? SAT : oe_high_run + 1'b1);
      we_low_run  <= sram_we_n ? '0 : ((we_low_run == SAT) ? SAT : we_low_run + 1'b1);
      dq_oe_prev  <= sram_dq_oe;
      if (ev_sample)
        p_access_len_r3: assert (oe_low_run >= RW'(RD))
          else $error("read sampled after %0d cycles", oe_low_run);
      if (ev_pulse_end)
        p_pulse_len_r7: assert (we_low_run + 1'b1 >= RW'(PW))
          else $error("write pulse of %0d cycles", we_low_run + 1'b1);
      if (sram_dq_oe && !dq_oe_prev)
        p_float_gap_r5: assert (oe_high_run >= RW'(FL))
          else $error("drivers on %0d cycles after output enable rose", oe_high_run);
    end
  end

  p_idle_ce_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce_n);
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  p_rsp_follows_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |=> rsp_valid);
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq_oe && $stable(sram_dq_out)));
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));
  p_lanes_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_ub_n && sram_lb_n));
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);
  p_no_drive_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_ACCESS_NS(T_ACCESS_NS),
  .T_OE_ACCESS_NS(T_OE_ACCESS_NS), .T_FLOAT_NS(T_FLOAT_NS),
  .T_ADDR_SETUP_NS(T_ADDR_SETUP_NS), .T_WE_PULSE_NS(T_WE_PULSE_NS),
  .T_DATA_SETUP_NS(T_DATA_SETUP_NS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .ev_accept    (ev_accept),
  .ev_sample    (ev_sample),
  .ev_pulse_end (ev_pulse_end),
  .rsp_valid    (rsp_valid),
  .sram_addr    (sram_addr),
  .sram_ce_n    (sram_ce_n),
  .sram_we_n    (sram_we_n),
  .sram_oe_n    (sram_oe_n),
  .sram_ub_n    (sram_ub_n),
  .sram_lb_n    (sram_lb_n),
  .sram_dq_oe   (sram_dq_oe),
  .sram_dq_out  (sram_dq_out)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe;
  logic [15:0] sram_dq_out, sram_dq_in;

  always #2 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int e_rd, e_fl, e_su, e_pw, e_rc;

  function automatic int up(input int ns);
    int c;
    c = ns / P;
    if (c * P < ns) c++;
    if (c < 1) c = 1;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // ---------------- memory model (64 words, selected by low address bits) ----
  logic [15:0] mem [64];
  bit          wflag [64];
  logic [7:0]  rd_cnt = '0;
  logic        rd_cond;

  function automatic logic [15:0] word_at(input logic [17:0] a);
    return wflag[a[5:0]] ? mem[a[5:0]] : (a[15:0] ^ 16'hA5C3);
  endfunction

  assign rd_cond = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign sram_dq_in[15:8] = (rd_cond && !sram_ub_n && rd_cnt >= 8'(e_rd)) ? word_at(sram_addr) >> 8 : 8'hD7;
  assign sram_dq_in[7:0]  = (rd_cond && !sram_lb_n && rd_cnt >= 8'(e_rd)) ? word_at(sram_addr) & 16'h00FF : 8'hEE;

  always @(posedge clk) rd_cnt <= rd_cond ? ((rd_cnt == 8'hFF) ? rd_cnt : rd_cnt + 8'd1) : 8'd0;

  // Pin monitor at the falling edge.
  int          we_run = 0, oe_hi_run = 1000;
  bit          oe_prev_drv = 0;
  logic [17:0] lw_addr;
  logic [15:0] lw_data;
  logic        lw_ub, lw_lb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe && !sram_oe_n) chk(0, "R10 drivers on during read", 1, 0);
      if (!sram_oe_n && !sram_we_n) chk(0, "R10 oe and we both low", 0, 1);
      if (sram_dq_oe && !oe_prev_drv) chk(oe_hi_run >= e_fl, "R5 float gap", oe_hi_run, e_fl);
      oe_prev_drv = sram_dq_oe;
      oe_hi_run = sram_oe_n ? oe_hi_run + 1 : 0;
      if (!sram_we_n) begin
        if (we_run > 0)
          chk(sram_addr == lw_addr && sram_dq_out == lw_data && sram_dq_oe,
              "R7 address/data held in pulse", {sram_addr, sram_dq_out}, {lw_addr, lw_data});
        lw_addr = sram_addr; lw_data = sram_dq_out;
        lw_ub = !sram_ub_n; lw_lb = !sram_lb_n;
        we_run++;
      end else if (we_run > 0) begin
        logic [15:0] old;
        chk(we_run >= up(40), "R7 pulse length", we_run, up(40));
        chk(sram_addr == lw_addr, "R8 address at we rise", sram_addr, lw_addr);
        old = word_at(lw_addr);
        mem[lw_addr[5:0]] = {lw_ub ? lw_data[15:8] : old[15:8], lw_lb ? lw_data[7:0] : old[7:0]};
        wflag[lw_addr[5:0]] = 1;
        we_run = 0;
      end
    end
  end

  // ---------------- transactions ---------------------------------------------
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    chk(req_ready, "R2 ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m, input logic [15:0] exp, input bit junk);
    int last;
    logic [4:0] act, ev;
    string tag;
    last = e_rd + 1 + e_fl + 1;
    issue(1'b0, a, 16'h0, m);
    for (int k = 1; k <= last; k++) begin
      if (k > 1) @(negedge clk);
      act = {sram_ce_n, sram_oe_n, sram_we_n, req_ready, rsp_valid};
      ev  = {k == last, k > e_rd + 1, 1'b1, k == last, k == e_rd + 2};
      tag = (k == last) ? "R2 read back to idle" : (k == e_rd + 2) ? "R4 response strobe" :
            (k > e_rd + 1) ? "R5 float phase" : "R3 read access strobes";
      chk(act == ev, tag, act, ev);
      if (k <= e_rd + 1)
        chk(sram_addr == a && sram_ub_n == !m[1] && sram_lb_n == !m[0], "R9 read address and lanes",
            {sram_addr, sram_ub_n, sram_lb_n}, {a, !m[1], !m[0]});
      if (k == e_rd + 2) chk(rsp_rdata == exp, "R4 read data", rsp_rdata, exp);
      if (junk && k == 3) begin
        req_valid = 1; req_write = 1; req_addr = a ^ 18'h00007; req_wdata = 16'hFFFF; req_bmask = 2'b11;
      end
      if (junk && k == last) req_valid = 0;
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int last;
    logic [4:0] act, ev;
    string tag;
    last = e_su + e_pw + e_rc + 1;
    issue(1'b1, a, d, m);
    for (int k = 1; k <= last; k++) begin
      if (k > 1) @(negedge clk);
      act = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready};
      ev  = {k == last, !(k > e_su && k <= e_su + e_pw), 1'b1, k <= e_su + e_pw, k == last};
      tag = (k == last) ? "R2 write back to idle" : (k <= e_su) ? "R6 setup strobes" :
            (k <= e_su + e_pw) ? "R7 pulse strobes" : "R8 recovery strobes";
      chk(act == ev, tag, act, ev);
      if (k < last)
        chk(sram_addr == a && sram_ub_n == !m[1] && sram_lb_n == !m[0], "R9 write address and lanes",
            {sram_addr, sram_ub_n, sram_lb_n}, {a, !m[1], !m[0]});
      if (k <= e_su + e_pw) chk(sram_dq_out == d, "R6 write data driven", sram_dq_out, d);
    end
  endtask

  function automatic logic [15:0] keep(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [17:0] addrs [4];
    logic [15:0] w1, w2, merged;
    addrs[0] = 18'h00000; addrs[1] = 18'h3FFFF; addrs[2] = 18'h15555; addrs[3] = 18'h2AAAA;
    for (int i = 0; i < 64; i++) wflag[i] = 0;
    e_rd = (up(55) > up(25)) ? up(55) : up(25);
    e_fl = up(20);
    e_su = up(0);
    e_pw = (up(40) > up(25) - e_su) ? up(40) : up(25) - e_su;
    e_rc = (up(55) - e_su - e_pw < 1) ? 1 : up(55) - e_su - e_pw;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk({req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe, rsp_valid} == 8'b1111_1100,
        "R1 reset outputs", {req_ready, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe, rsp_valid},
        8'b1111_1100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && sram_ce_n, "R2 idle after reset", {req_ready, sram_ce_n}, 2'b11);

    // Unwritten words, every mask
    for (int m = 0; m < 4; m++)
      do_read(addrs[2], 2'(m), keep(addrs[2][15:0] ^ 16'hA5C3, 2'(m)), 0);

    // Sweep addresses and masks: full write, masked write, read back two ways
    foreach (addrs[i]) begin
      for (int m = 0; m < 4; m++) begin
        w1 = addrs[i][15:0] ^ 16'h1357 ^ {4{2'(m), 2'(m)}};
        w2 = ~w1 ^ 16'h0F0F;
        merged = {m[1] ? w2[15:8] : w1[15:8], m[0] ? w2[7:0] : w1[7:0]};
        do_write(addrs[i], w1, 2'b11);
        do_write(addrs[i], w2, 2'(m));
        do_read(addrs[i], 2'b11, merged, 0);
        do_read(addrs[i], 2'(m), keep(merged, 2'(m)), 0);
      end
    end

    // R2: a request offered while busy is ignored
    do_write(18'h00010, 16'h4C2B, 2'b11);
    do_write(18'h00017, 16'h7A19, 2'b11);
    do_read(18'h00010, 2'b11, 16'h4C2B, 1);
    @(negedge clk);
    chk(req_ready && sram_ce_n, "R2 busy request not taken", {req_ready, sram_ce_n}, 2'b11);
    do_read(18'h00017, 2'b11, 16'h7A19, 0);

    summary();
  end

endmodule